// File: doc/BRIEF.md
# Multi-operand carry-save sum tree

This block adds a configurable number of operands into a single result of a chosen output width, wrapping modulo two to the output width. Every operand carries two flags of its own: one says whether it is a two's-complement or a plain binary value, the other says whether it is added or subtracted. The block is meant for datapaths that would otherwise chain several adders, such as accumulating many terms of a filter or a checksum.

Internally every operand is first sized to the output width and, if it is subtracted, bitwise inverted. One more input vector carries the count of subtracted operands, which completes the two's complement. The resulting vectors are reduced by layers of bitwise 3:2 compressors. The grouping of vectors into compressors is fixed when the design is elaborated: at each level only vectors that are already available are combined, three at a time, and the rest wait. When two vectors remain, one carry-propagate adder produces the result. An optional output register adds one cycle of latency.

Top module: `csa_sum_tree`

## Requirements
- R1: An operand narrower than the output is sign-extended when its signed flag is 1 and zero-extended when the flag is 0.
- R2: An operand wider than the output contributes only its low OUT_W bits; the bits above them have no effect on sum_o.
- R3: The result equals the exact signed sum reduced modulo 2^OUT_W, so carries past the top bit are dropped without any indication.
- R4: An operand whose subtract flag is 1 is subtracted from the total instead of added; the flag acts on each operand on its own.
- R5: For any N_OPS of 3 or more, the compressor tree gives the same result as a plain sequential sum of all the sized and signed operands.
- R6: When every operand is subtracted, the result is the two's-complement negation of their sum, which requires a correction of N_OPS to be added.
- R7: With REG_OUT = 1, sum_o shows the result of the inputs present at the previous rising clock edge and holds it while the inputs are steady.
- R8: With REG_OUT = 1, driving rst_ni low forces sum_o to zero at once, without waiting for a clock edge, and keeps it there while rst_ni is low.
- R9: With REG_OUT = 0, sum_o follows the inputs within the same cycle and is not affected by clk_i or rst_ni.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| ops_i | input | N_OPS*IN_W | Packed operands, operand i in bits [i*IN_W +: IN_W] |
| signed_i | input | N_OPS | Bit i = 1: operand i is two's-complement |
| sub_i | input | N_OPS | Bit i = 1: operand i is subtracted |
| sum_o | output | OUT_W | Sum modulo 2^OUT_W |

## Verification
The bench builds four copies side by side: three operands of 8 bits into a 12-bit combinational result, four 16-bit operands truncated into a registered 10-bit result, seven 8-bit operands into a registered 8-bit result, and nine 6-bit operands into a combinational 11-bit result. Together they reach both extension and truncation, operand counts whose schedules skip or defer vectors at different levels, and both output variants. All four are driven from one shared stimulus, so each pattern of all-ones, most-negative, mixed-flag and random operands is checked at every operand count at once, and the latency and reset behaviour of the registered copies is compared against the combinational ones in the same cycle.

// File: rtl/csa_pkg.sv
package csa_pkg;

  localparam int MAX_VECS = 64;

  // Elaboration-time schedule of the compressor tree.
  // Vectors 0..n_vecs-1 are the tree inputs; compressor k writes vectors
  // n_vecs+2k (sum) and n_vecs+2k+1 (shifted carry).
  // For k_want < n_vecs-2: returns input j (0..2) of compressor k_want.
  // For k_want = n_vecs-2: returns final vector j (0..1).
  function automatic int sched_src(int n_vecs, int k_want, int j);
    int cur_s [MAX_VECS];
    int cur_d [MAX_VECS];
    int rdy_s [MAX_VECS];
    int rdy_d [MAX_VECS];
    int wt_s  [MAX_VECS];
    int wt_d  [MAX_VECS];
    int nx_s  [MAX_VECS];
    int nx_d  [MAX_VECS];
    int cnt, n_rdy, n_wt, n_nx, level, fresh, k, dmax, res, grp;
    bit done;
    cnt   = n_vecs;
    level = 0;
    fresh = n_vecs;
    k     = 0;
    res   = 0;
    done  = 1'b0;
    for (int i = 0; i < MAX_VECS; i++) begin
      cur_s[i] = (i < n_vecs) ? i : 0;
      cur_d[i] = 0;
      rdy_s[i] = 0;
      rdy_d[i] = 0;
      wt_s[i]  = 0;
      wt_d[i]  = 0;
      nx_s[i]  = 0;
      nx_d[i]  = 0;
    end
    while (cnt > 2 && level < 4 * MAX_VECS) begin
      n_rdy = 0;
      n_wt  = 0;
      for (int i = 0; i < MAX_VECS; i++) begin
        if (i < cnt) begin
          if (cur_d[i] <= level) begin
            rdy_s[n_rdy] = cur_s[i];
            rdy_d[n_rdy] = cur_d[i];
            n_rdy++;
          end else begin
            wt_s[n_wt] = cur_s[i];
            wt_d[n_wt] = cur_d[i];
            n_wt++;
          end
        end
      end
      if (n_rdy >= 3) begin
        n_nx = 0;
        grp  = n_rdy / 3;
        for (int g = 0; g < MAX_VECS / 3; g++) begin
          if (g < grp) begin
            if (k == k_want && !done) begin
              res  = rdy_s[3*g+j];
              done = 1'b1;
            end
            dmax = rdy_d[3*g];
            if (rdy_d[3*g+1] > dmax) dmax = rdy_d[3*g+1];
            if (rdy_d[3*g+2] > dmax) dmax = rdy_d[3*g+2];
            nx_s[n_nx]   = fresh;
            nx_d[n_nx]   = dmax + 1;
            nx_s[n_nx+1] = fresh + 1;
            nx_d[n_nx+1] = dmax + 1;
            n_nx  += 2;
            fresh += 2;
            k++;
          end
        end
        for (int i = 0; i < MAX_VECS; i++) begin
          if (i >= 3 * grp && i < n_rdy) begin
            nx_s[n_nx] = rdy_s[i];
            nx_d[n_nx] = rdy_d[i];
            n_nx++;
          end
        end
        for (int i = 0; i < MAX_VECS; i++) begin
          if (i < n_wt) begin
            nx_s[n_nx] = wt_s[i];
            nx_d[n_nx] = wt_d[i];
            n_nx++;
          end
        end
        for (int i = 0; i < MAX_VECS; i++) begin
          cur_s[i] = nx_s[i];
          cur_d[i] = nx_d[i];
        end
        cnt = n_nx;
      end
      level++;
    end
    if (!done) res = cur_s[j];
    return res;
  endfunction

endpackage

// File: rtl/csa_operand_prep.sv
module csa_operand_prep #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  op_i,
  input  logic             sgn_i,
  input  logic             neg_i,
  output logic [OUT_W-1:0] vec_o
);

  logic [OUT_W-1:0] sized;

  if (IN_W >= OUT_W) begin : g_trunc
    assign sized = op_i[OUT_W-1:0];
  end else begin : g_ext
    assign sized = {{(OUT_W-IN_W){sgn_i & op_i[IN_W-1]}}, op_i};
  end

  // inversion; the +1 per subtracted operand enters via the correction vector
  assign vec_o = sized ^ {OUT_W{neg_i}};

endmodule

// File: rtl/csa_compress.sv
module csa_compress #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  logic [W-1:0] maj;

  assign sum_o   = a_i ^ b_i ^ c_i;
  assign maj     = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  // carry weighted one position up; top carry falls off (mod 2^W)
  assign carry_o = {maj[W-2:0], 1'b0};

endmodule

// File: rtl/csa_final_add.sv
module csa_final_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);

  assign sum_o = a_i + b_i;

endmodule

// File: rtl/csa_sum_tree.sv
module csa_sum_tree #(
  parameter int N_OPS   = 7,
  parameter int IN_W    = 8,
  parameter int OUT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_OPS-1:0][IN_W-1:0] ops_i,
  input  logic [N_OPS-1:0]           signed_i,
  input  logic [N_OPS-1:0]           sub_i,
  output logic [OUT_W-1:0]           sum_o
);

  localparam int N_VECS = N_OPS + 1;        // operands + correction vector
  localparam int N_CMP  = N_VECS - 2;       // each compressor removes one vector
  localparam int N_SLOT = N_VECS + 2 * N_CMP;

  if (N_OPS < 3 || N_VECS > csa_pkg::MAX_VECS || OUT_W < 2) begin : g_bad_cfg
    $error("csa_sum_tree: unsupported N_OPS/OUT_W");
  end

  logic [N_SLOT-1:0][OUT_W-1:0] vec;
  logic [OUT_W-1:0]             corr;
  logic [OUT_W-1:0]             sum_comb;

  for (genvar i = 0; i < N_OPS; i++) begin : g_prep
    csa_operand_prep #(
      .IN_W (IN_W),
      .OUT_W(OUT_W)
    ) i_prep (
      .op_i (ops_i[i]),
      .sgn_i(signed_i[i]),
      .neg_i(sub_i[i]),
      .vec_o(vec[i])
    );
  end

  always_comb begin
    corr = '0;
    for (int i = 0; i < N_OPS; i++) corr = corr + OUT_W'(sub_i[i]);
  end
  assign vec[N_OPS] = corr;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    localparam int SRC_A = csa_pkg::sched_src(N_VECS, k, 0);
    localparam int SRC_B = csa_pkg::sched_src(N_VECS, k, 1);
    localparam int SRC_C = csa_pkg::sched_src(N_VECS, k, 2);
    csa_compress #(
      .W(OUT_W)
    ) i_cmp (
      .a_i    (vec[SRC_A]),
      .b_i    (vec[SRC_B]),
      .c_i    (vec[SRC_C]),
      .sum_o  (vec[N_VECS+2*k]),
      .carry_o(vec[N_VECS+2*k+1])
    );
  end

  localparam int FIN_A = csa_pkg::sched_src(N_VECS, N_CMP, 0);
  localparam int FIN_B = csa_pkg::sched_src(N_VECS, N_CMP, 1);

  csa_final_add #(
    .W(OUT_W)
  ) i_fin (
    .a_i  (vec[FIN_A]),
    .b_i  (vec[FIN_B]),
    .sum_o(sum_comb)
  );

  if (REG_OUT) begin : g_reg
    logic [OUT_W-1:0] sum_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_q <= '0;
      else         sum_q <= sum_comb;
    end
    assign sum_o = sum_q;
  end else begin : g_comb
    assign sum_o = sum_comb;
  end

endmodule

// File: rtl/csa_sum_tree_chk.sv
module csa_sum_tree_chk #(
  parameter int N_OPS   = 7,
  parameter int IN_W    = 8,
  parameter int OUT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_OPS-1:0][IN_W-1:0] ops_i,
  input logic [N_OPS-1:0]           signed_i,
  input logic [N_OPS-1:0]           sub_i,
  input logic [OUT_W-1:0]           sum_comb,
  input logic [OUT_W-1:0]           sum_o
);

  logic [OUT_W-1:0] ref_sum;
  logic             past_valid;
  logic             rst_seen = 1'b0;

  // behavioural sum, independent of the tree structure
  always_comb begin
    ref_sum = '0;
    for (int i = 0; i < N_OPS; i++) begin
      logic signed [IN_W:0] wide;
      logic [OUT_W-1:0]     ext;
      wide = signed_i[i] ? $signed({ops_i[i][IN_W-1], ops_i[i]})
                         : $signed({1'b0, ops_i[i]});
      ext  = OUT_W'(wide);
      ref_sum = sub_i[i] ? ref_sum - ext : ref_sum + ext;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid <= 1'b0;
    else         past_valid <= 1'b1;
  end

  always_ff @(posedge clk_i) rst_seen <= rst_seen | !rst_ni;

  // R3 R4 R5: tree plus final adder equals the sequential sum
  a_r5_tree_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_comb == ref_sum);

  if (REG_OUT) begin : g_reg_chk
    a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_valid |-> sum_o == $past(sum_comb));

    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_valid && $stable(ops_i) && $stable(signed_i) && $stable(sub_i))
      |=> $stable(sum_o));

    a_r8_reset_clear: assert property (@(posedge clk_i)
      (!rst_ni && rst_seen) |-> sum_o == '0);
  end

endmodule

bind csa_sum_tree csa_sum_tree_chk #(
  .N_OPS  (N_OPS),
  .IN_W   (IN_W),
  .OUT_W  (OUT_W),
  .REG_OUT(REG_OUT)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ops_i   (ops_i),
  .signed_i(signed_i),
  .sub_i   (sub_i),
  .sum_comb(sum_comb),
  .sum_o   (sum_o)
);

// File: tb/test_csa_sum_tree.sv
`timescale 1ns/1ps
module test_csa_sum_tree;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  longint     op_v [9];
  logic [8:0] sgn_v;
  logic [8:0] sub_v;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // n3: extension, combinational
  logic [2:0][7:0]  ops_n3;
  logic [11:0]      sum_n3;
  // n4: truncation, registered
  logic [3:0][15:0] ops_n4;
  logic [9:0]       sum_n4;
  // n7: equal widths, registered
  logic [6:0][7:0]  ops_n7;
  logic [7:0]       sum_n7;
  // n9: extension, combinational
  logic [8:0][5:0]  ops_n9;
  logic [10:0]      sum_n9;

  always_comb for (int i = 0; i < 3; i++) ops_n3[i] = op_v[i][7:0];
  always_comb for (int i = 0; i < 4; i++) ops_n4[i] = op_v[i][15:0];
  always_comb for (int i = 0; i < 7; i++) ops_n7[i] = op_v[i][7:0];
  always_comb for (int i = 0; i < 9; i++) ops_n9[i] = op_v[i][5:0];

  csa_sum_tree #(.N_OPS(3), .IN_W(8), .OUT_W(12), .REG_OUT(1'b0)) i_csa_sum_tree_n3 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ops_i(ops_n3),
    .signed_i(sgn_v[2:0]), .sub_i(sub_v[2:0]), .sum_o(sum_n3));

  csa_sum_tree #(.N_OPS(4), .IN_W(16), .OUT_W(10), .REG_OUT(1'b1)) i_csa_sum_tree_n4 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ops_i(ops_n4),
    .signed_i(sgn_v[3:0]), .sub_i(sub_v[3:0]), .sum_o(sum_n4));

  csa_sum_tree #(.N_OPS(7), .IN_W(8), .OUT_W(8), .REG_OUT(1'b1)) i_csa_sum_tree (
    .clk_i(clk_i), .rst_ni(rst_ni), .ops_i(ops_n7),
    .signed_i(sgn_v[6:0]), .sub_i(sub_v[6:0]), .sum_o(sum_n7));

  csa_sum_tree #(.N_OPS(9), .IN_W(6), .OUT_W(11), .REG_OUT(1'b0)) i_csa_sum_tree_n9 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ops_i(ops_n9),
    .signed_i(sgn_v), .sub_i(sub_v), .sum_o(sum_n9));

  function automatic longint exp_sum(int n, int iw, int w);
    longint acc = 0;
    for (int i = 0; i < n; i++) begin
      longint v;
      v = op_v[i] & ((longint'(1) << iw) - 1);
      if (sgn_v[i] && v[iw-1]) v = v - (longint'(1) << iw);
      acc = sub_v[i] ? acc - v : acc + v;
    end
    return acc & ((longint'(1) << w) - 1);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "n3", longint'(sum_n3), exp_sum(3, 8, 12));
    chk(req, "n4", longint'(sum_n4), exp_sum(4, 16, 10));
    chk(req, "n7", longint'(sum_n7), exp_sum(7, 8, 8));
    chk(req, "n9", longint'(sum_n9), exp_sum(9, 6, 11));
  endtask

  task automatic fill(longint v, logic [8:0] s, logic [8:0] b);
    for (int i = 0; i < 9; i++) op_v[i] = v;
    sgn_v = s;
    sub_v = b;
  endtask

  // drive at negedge, let the register capture, sample at next negedge
  task automatic settle();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    fill(64'h15, '1, '0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R8", "n4 in reset", longint'(sum_n4), 0);
    chk("R8", "n7 in reset", longint'(sum_n7), 0);
    chk("R9", "n3 in reset", longint'(sum_n3), exp_sum(3, 8, 12));
    chk("R9", "n9 in reset", longint'(sum_n9), exp_sum(9, 6, 11));
    rst_ni = 1'b1;
  endtask

  task automatic t_unsigned_ext();
    fill(64'hFFFF, '0, '0);      // R1 zero extension, R3 wrap
    settle();
    chk_all("R1");
    chk("R1", "n3 zero-ext 3*255", longint'(sum_n3), 765);
  endtask

  task automatic t_signed_ext();
    fill(64'hFFFF, '1, '0);      // every operand is -1
    settle();
    chk_all("R1");
    chk("R1", "n9 nine -1", longint'(sum_n9), 11'h7F7);
  endtask

  task automatic t_most_negative();
    longint mins[3] = '{64'h20, 64'h80, 64'h8000};
    foreach (mins[m]) begin
      fill(mins[m], '1, '0);
      settle();
      chk_all("R1");
      fill(mins[m], '1, 9'h0AA);
      settle();
      chk_all("R4");
    end
  endtask

  task automatic t_mixed_sign();
    fill(64'hC3, 9'b101010101, 9'b000000000);
    op_v[1] = 64'h3F; op_v[4] = 64'h80;
    settle();
    chk_all("R1");
  endtask

  task automatic t_truncation();
    // n4: only the low 10 bits of each 16-bit operand count
    fill(64'h0005, '0, '0);
    settle();
    chk("R2", "n4 low", longint'(sum_n4), 20);
    fill(64'hFC05, '0, '0);
    settle();
    chk("R2", "n4 upper ignored", longint'(sum_n4), 20);
    fill(64'hFC05, '1, '0);
    settle();
    chk("R2", "n4 sign above W ignored", longint'(sum_n4), 20);
    chk_all("R2");
  endtask

  task automatic t_wrap();
    fill(64'h7F, '0, '0);
    settle();
    chk("R3", "n7 7*127 mod 256", longint'(sum_n7), (7 * 127) % 256);
    chk_all("R3");
  endtask

  task automatic t_subtract();
    fill(64'h0, '0, 9'b000000010);
    op_v[0] = 10; op_v[1] = 3; op_v[2] = 1;
    settle();
    chk("R4", "n3 10-3+1", longint'(sum_n3), 8);
    sub_v = 9'b000000011;
    settle();
    chk("R4", "n3 -10-3+1", longint'(sum_n3), 12'hFF4);
    chk_all("R4");
  endtask

  task automatic t_all_sub();
    fill(64'h1, '0, '1);
    settle();
    chk("R6", "n9 -9", longint'(sum_n9), 11'h7F7);
    chk("R6", "n7 -7", longint'(sum_n7), 8'hF9);
    fill(64'h0, '0, '1);
    settle();
    chk_all("R6");
    fill(64'hFFFF, 9'b011001100, '1);
    settle();
    chk_all("R6");
  endtask

  task automatic t_random();
    for (int r = 0; r < 60; r++) begin
      for (int i = 0; i < 9; i++) op_v[i] = longint'({$urandom, $urandom});
      sgn_v = 9'($urandom);
      sub_v = 9'($urandom);
      settle();
      chk_all("R5");
    end
  endtask

  task automatic t_latency();
    longint prev4, prev7;
    fill(64'h11, '0, '0);
    settle();
    prev4 = exp_sum(4, 16, 10);
    prev7 = exp_sum(7, 8, 8);
    fill(64'h23, '1, 9'h005);
    #1;
    chk("R7", "n4 before edge", longint'(sum_n4), prev4);
    chk("R7", "n7 before edge", longint'(sum_n7), prev7);
    chk("R9", "n3 same cycle", longint'(sum_n3), exp_sum(3, 8, 12));
    chk("R9", "n9 same cycle", longint'(sum_n9), exp_sum(9, 6, 11));
    @(negedge clk_i);
    chk("R7", "n4 after edge", longint'(sum_n4), exp_sum(4, 16, 10));
    chk("R7", "n7 after edge", longint'(sum_n7), exp_sum(7, 8, 8));
    repeat (3) @(negedge clk_i);
    chk("R7", "n7 held", longint'(sum_n7), exp_sum(7, 8, 8));
  endtask

  task automatic t_async_reset();
    fill(64'h3, '0, '0);
    settle();
    chk("R8", "n7 before reset", longint'(sum_n7), 21);
    rst_ni = 1'b0;
    #1;
    chk("R8", "n4 async clear", longint'(sum_n4), 0);
    chk("R8", "n7 async clear", longint'(sum_n7), 0);
    chk("R9", "n3 unaffected", longint'(sum_n3), 9);
    @(negedge clk_i);
    chk("R8", "n7 held in reset", longint'(sum_n7), 0);
    rst_ni = 1'b1;
    settle();
    chk_all("R8");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    fill(64'h0, '0, '0);
    @(negedge clk_i);
    t_reset();
    t_unsigned_ext();
    t_signed_ext();
    t_most_negative();
    t_mixed_sign();
    t_truncation();
    t_wrap();
    t_subtract();
    t_all_sub();
    t_random();
    t_latency();
    t_async_reset();
    finish_run();
  end

endmodule